// File: doc/BRIEF.md
# Per-Lane Work-Item Coordinate Generator

This block turns the launch description of one wave of a workgroup into the per-lane identity data that each lane needs before it runs. It takes the effective workgroup extent in X and Y, the total number of work-items in the group, a wave index and the fixed wave width. From these it emits, one lane per clock, the lane's local X/Y/Z coordinate, its flattened local id and whether the lane is live. The item number of a lane is its lane index plus the wave index times the wave width. A lane is live only when that item number is below the work-item total, so the last wave of a ragged group comes out partly masked.

The same launch also splits a flat workgroup id into three workgroup coordinates, using the number of workgroups along X and Y. Neither split uses a hardware divider. The coordinates of lane 0 and of the workgroup are found once, at launch, by repeated subtraction. Two subtraction engines run side by side. After that, the lane coordinates advance with wrapping counters: X wraps at the X extent and carries into Y, and Y wraps at the Y extent and carries into Z. When the last lane record has gone out, the assembled live-lane vector and the workgroup coordinates are presented together with a one-cycle done pulse.

Top module: `wid_lane_gen`

## Requirements
- R1: A start pulse is taken only while `busy` is low, and `busy` is high on the next cycle. A start pulse while `busy` is high has no effect: it causes no extra records and does not change the records of the run in progress.
- R2: Each accepted start produces exactly LANES records. Each record is marked by `lane_vld`. The records come on consecutive cycles with `lane_idx` counting 0, 1, ..., LANES-1.
- R3: For the lane with item number g = lane_idx + wave_idx × LANES, `lane_flat` equals z × sizeX × sizeY + y × sizeX + x, which is g itself.
- R4: `lane_x` = g mod sizeX, `lane_y` = (g div sizeX) mod sizeY, and `lane_z` = g div (sizeX × sizeY).
- R5: `lane_on` is 1 exactly when g < `item_total`; otherwise it is 0. This includes a wave that is only partly inside the group.
- R6: Lanes with `lane_on` = 0 still carry coordinates and a flat id given by the same formulas as live lanes.
- R7: `done` is a single-cycle pulse on the cycle after the record of lane LANES-1. At that point, bit i of `exec_mask` equals `lane_on` of lane i. `exec_mask` changes only in a cycle where `done` is high, and holds its value until the next done.
- R8: With `done`, `grp_x` = id mod numX, `grp_y` = (id div numX) mod numY and `grp_z` = id div (numX × numY). Here id is `grp_id`, numX is `grp_cnt_x` and numY is `grp_cnt_y`. These outputs hold until the next done.
- R9: A zero value of `size_x`, `size_y`, `grp_cnt_x` or `grp_cnt_y` is treated as one.
- R10: After reset, `busy`, `lane_vld` and `done` are 0, and `exec_mask` and the workgroup coordinates are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| size_x | input | DIM_W | Workgroup extent along X |
| size_y | input | DIM_W | Workgroup extent along Y |
| item_total | input | G_W+1 | Number of work-items in the group |
| wave_idx | input | WAVE_W | Index of this wave within the group |
| grp_id | input | GRP_W | Flat workgroup id |
| grp_cnt_x | input | DIM_W | Workgroups along X |
| grp_cnt_y | input | DIM_W | Workgroups along Y |
| busy | output | 1 | A launch is in progress |
| lane_vld | output | 1 | Lane record valid this cycle |
| lane_idx | output | LANE_BITS | Lane number of the record |
| lane_x | output | DIM_W | Local X coordinate |
| lane_y | output | DIM_W | Local Y coordinate |
| lane_z | output | G_W | Local Z coordinate |
| lane_flat | output | G_W | Flattened local id |
| lane_on | output | 1 | Lane is live |
| done | output | 1 | One-cycle pulse after the last record |
| exec_mask | output | LANES | Assembled live-lane vector |
| grp_x | output | DIM_W | Workgroup X coordinate |
| grp_y | output | DIM_W | Workgroup Y coordinate |
| grp_z | output | GRP_W | Workgroup Z coordinate |

## Verification
The hardest case to reach from the ports is a wave that crosses a Z-plane boundary and also crosses the work-item total. Both the double carry (X wrapping into Y wrapping into Z) and the live-to-dead edge then fall inside one run. The stimulus reaches it by choosing small extents, a nonzero wave index and a total that ends inside the wave. A restart request is also injected in the middle of a run. The queued expectations then show whether that request disturbed anything. Zero extents and a zero total drive the clamping and the all-dead mask.

// File: rtl/wid_pkg.sv
package wid_pkg;

    localparam int unsigned DEF_LANES  = 16;
    localparam int unsigned DEF_DIM_W  = 8;
    localparam int unsigned DEF_WAVE_W = 8;
    localparam int unsigned DEF_GRP_W  = 16;

    // Launch sequencing phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SPLIT1,   // item base / sizeX and group id / numX
        PH_SPLIT2,   // quotients / sizeY and / numY
        PH_WALK,     // one lane record per cycle
        PH_FIN       // present mask and group coordinates
    } phase_e;

    // Wrap indications of the coordinate walker
    typedef struct packed {
        logic x_wrap;
        logic y_wrap;
    } carry_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned lane_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wid_subdiv.sv
module wid_subdiv #(
    parameter int unsigned NUM_W = 16,
    parameter int unsigned DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo,
    output logic [NUM_W-1:0] rem
);
    logic             running;
    logic [NUM_W-1:0] den_q;

    // Repeated subtraction; den is nonzero (clamped by the caller)
    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            fin     <= 1'b0;
            quo     <= '0;
            rem     <= '0;
            den_q   <= NUM_W'(1);
        end else begin
            fin <= 1'b0;
            if (go) begin
                running <= 1'b1;
                rem     <= num;
                quo     <= '0;
                den_q   <= NUM_W'(den);
            end else if (running) begin
                if (rem >= den_q) begin
                    rem <= rem - den_q;
                    quo <= quo + NUM_W'(1);
                end else begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wid_lane_walk.sv
module wid_lane_walk
    import wid_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned DIM_W = DEF_DIM_W,
    parameter int unsigned G_W   = 12,
    parameter int unsigned TOT_W = 13
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic                           step,
    input  logic [DIM_W-1:0]               sx,
    input  logic [DIM_W-1:0]               sy,
    input  logic [TOT_W-1:0]               total,
    input  logic [DIM_W-1:0]               x0,
    input  logic [DIM_W-1:0]               y0,
    input  logic [G_W-1:0]                 z0,
    input  logic [G_W-1:0]                 g0,
    output logic [DIM_W-1:0]               cur_x,
    output logic [DIM_W-1:0]               cur_y,
    output logic [G_W-1:0]                 cur_z,
    output logic [G_W-1:0]                 cur_g,
    output logic [lane_bits(LANES)-1:0]    cur_lane,
    output logic                           cur_on,
    output logic                           last
);
    localparam int unsigned LB = lane_bits(LANES);
    localparam int unsigned EW = DIM_W + 1;

    carry_t cy;

    always_comb begin
        cy.x_wrap = (EW'(cur_x) + EW'(1)) >= EW'(sx);
        cy.y_wrap = (EW'(cur_y) + EW'(1)) >= EW'(sy);
    end

    assign cur_on = TOT_W'(cur_g) < total;
    assign last   = cur_lane == LB'(LANES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_x    <= '0;
            cur_y    <= '0;
            cur_z    <= '0;
            cur_g    <= '0;
            cur_lane <= '0;
        end else if (load) begin
            cur_x    <= x0;
            cur_y    <= y0;
            cur_z    <= z0;
            cur_g    <= g0;
            cur_lane <= '0;
        end else if (step) begin
            cur_g    <= cur_g + G_W'(1);
            cur_lane <= cur_lane + LB'(1);
            if (cy.x_wrap) begin
                cur_x <= '0;
                if (cy.y_wrap) begin
                    cur_y <= '0;
                    cur_z <= cur_z + G_W'(1);
                end else begin
                    cur_y <= cur_y + DIM_W'(1);
                end
            end else begin
                cur_x <= cur_x + DIM_W'(1);
            end
        end
    end
endmodule

// File: rtl/wid_flat_calc.sv
module wid_flat_calc #(
    parameter int unsigned DIM_W = 8,
    parameter int unsigned G_W   = 12
) (
    input  logic [DIM_W-1:0] x,
    input  logic [DIM_W-1:0] y,
    input  logic [G_W-1:0]   z,
    input  logic [DIM_W-1:0] sx,
    input  logic [DIM_W-1:0] sy,
    output logic [G_W-1:0]   flat
);
    localparam int unsigned P_W = G_W + 2 * DIM_W;

    // (z*sy + y)*sx + x  ==  z*sx*sy + y*sx + x
    assign flat = G_W'((P_W'(z) * P_W'(sy) + P_W'(y)) * P_W'(sx) + P_W'(x));
endmodule

// File: rtl/wid_lane_gen.sv
module wid_lane_gen
    import wid_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned DIM_W  = DEF_DIM_W,
    parameter int unsigned WAVE_W = DEF_WAVE_W,
    parameter int unsigned GRP_W  = DEF_GRP_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [DIM_W-1:0]                       size_x,
    input  logic [DIM_W-1:0]                       size_y,
    input  logic [WAVE_W+lane_bits(LANES):0]       item_total,
    input  logic [WAVE_W-1:0]                      wave_idx,
    input  logic [GRP_W-1:0]                       grp_id,
    input  logic [DIM_W-1:0]                       grp_cnt_x,
    input  logic [DIM_W-1:0]                       grp_cnt_y,
    output logic                                   busy,
    output logic                                   lane_vld,
    output logic [lane_bits(LANES)-1:0]            lane_idx,
    output logic [DIM_W-1:0]                       lane_x,
    output logic [DIM_W-1:0]                       lane_y,
    output logic [WAVE_W+lane_bits(LANES)-1:0]     lane_z,
    output logic [WAVE_W+lane_bits(LANES)-1:0]     lane_flat,
    output logic                                   lane_on,
    output logic                                   done,
    output logic [LANES-1:0]                       exec_mask,
    output logic [DIM_W-1:0]                       grp_x,
    output logic [DIM_W-1:0]                       grp_y,
    output logic [GRP_W-1:0]                       grp_z
);
    localparam int unsigned LB    = lane_bits(LANES);
    localparam int unsigned G_W   = WAVE_W + LB;
    localparam int unsigned TOT_W = G_W + 1;
    localparam int unsigned DIV_W = max2(G_W, GRP_W);
    localparam int unsigned NDIV  = 2;   // 0: lane path, 1: group path

    phase_e ph;

    // Captured launch values (extents already clamped)
    logic [DIM_W-1:0] sx_q, sy_q, nx_q, ny_q;
    logic [TOT_W-1:0] tot_q;
    logic [G_W-1:0]   g0_q;
    logic [GRP_W-1:0] gid_q;

    // Intermediate results
    logic [DIM_W-1:0] x0_q, wgx_q, wgy_q;
    logic [GRP_W-1:0] wgz_q;
    logic [LANES-1:0] mask_acc;

    // Divider bank
    logic             go;
    logic [NDIV-1:0]  got;
    logic [NDIV-1:0]  fin_bits;
    logic [DIV_W-1:0] num_v [NDIV];
    logic [DIM_W-1:0] den_v [NDIV];
    logic [DIV_W-1:0] quo_v [NDIV];
    logic [DIV_W-1:0] rem_v [NDIV];
    logic             both_fin;

    always_comb begin
        if (ph == PH_SPLIT2) begin
            num_v[0] = quo_v[0];
            den_v[0] = sy_q;
            num_v[1] = quo_v[1];
            den_v[1] = ny_q;
        end else begin
            num_v[0] = DIV_W'(g0_q);
            den_v[0] = sx_q;
            num_v[1] = DIV_W'(gid_q);
            den_v[1] = nx_q;
        end
    end

    for (genvar i = 0; i < NDIV; i++) begin : g_div
        wid_subdiv #(.NUM_W(DIV_W), .DEN_W(DIM_W)) div_i (
            .clk (clk),
            .rst (rst),
            .go  (go),
            .num (num_v[i]),
            .den (den_v[i]),
            .fin (fin_bits[i]),
            .quo (quo_v[i]),
            .rem (rem_v[i])
        );
    end

    assign both_fin = &(got | fin_bits);

    // Coordinate walker
    logic                  walk_load, walk_step, walk_on, walk_last;
    logic [DIM_W-1:0]      walk_x, walk_y;
    logic [G_W-1:0]        walk_z, walk_g, walk_flat;
    logic [LB-1:0]         walk_lane;

    assign walk_load = (ph == PH_SPLIT2) && both_fin;
    assign walk_step = (ph == PH_WALK);

    wid_lane_walk #(.LANES(LANES), .DIM_W(DIM_W), .G_W(G_W), .TOT_W(TOT_W)) walk_i (
        .clk      (clk),
        .rst      (rst),
        .load     (walk_load),
        .step     (walk_step),
        .sx       (sx_q),
        .sy       (sy_q),
        .total    (tot_q),
        .x0       (x0_q),
        .y0       (DIM_W'(rem_v[0])),
        .z0       (G_W'(quo_v[0])),
        .g0       (g0_q),
        .cur_x    (walk_x),
        .cur_y    (walk_y),
        .cur_z    (walk_z),
        .cur_g    (walk_g),
        .cur_lane (walk_lane),
        .cur_on   (walk_on),
        .last     (walk_last)
    );

    wid_flat_calc #(.DIM_W(DIM_W), .G_W(G_W)) flat_i (
        .x    (walk_x),
        .y    (walk_y),
        .z    (walk_z),
        .sx   (sx_q),
        .sy   (sy_q),
        .flat (walk_flat)
    );

    assign busy = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            go        <= 1'b0;
            got       <= '0;
            sx_q      <= DIM_W'(1);
            sy_q      <= DIM_W'(1);
            nx_q      <= DIM_W'(1);
            ny_q      <= DIM_W'(1);
            tot_q     <= '0;
            g0_q      <= '0;
            gid_q     <= '0;
            x0_q      <= '0;
            wgx_q     <= '0;
            wgy_q     <= '0;
            wgz_q     <= '0;
            mask_acc  <= '0;
            lane_vld  <= 1'b0;
            lane_idx  <= '0;
            lane_x    <= '0;
            lane_y    <= '0;
            lane_z    <= '0;
            lane_flat <= '0;
            lane_on   <= 1'b0;
            done      <= 1'b0;
            exec_mask <= '0;
            grp_x     <= '0;
            grp_y     <= '0;
            grp_z     <= '0;
        end else begin
            go       <= 1'b0;
            lane_vld <= 1'b0;
            done     <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        sx_q     <= (size_x == '0) ? DIM_W'(1) : size_x;
                        sy_q     <= (size_y == '0) ? DIM_W'(1) : size_y;
                        nx_q     <= (grp_cnt_x == '0) ? DIM_W'(1) : grp_cnt_x;
                        ny_q     <= (grp_cnt_y == '0) ? DIM_W'(1) : grp_cnt_y;
                        tot_q    <= item_total;
                        g0_q     <= G_W'(wave_idx) * G_W'(LANES);
                        gid_q    <= grp_id;
                        mask_acc <= '0;
                        got      <= '0;
                        go       <= 1'b1;
                        ph       <= PH_SPLIT1;
                    end
                end
                PH_SPLIT1: begin
                    if (both_fin) begin
                        x0_q  <= DIM_W'(rem_v[0]);
                        wgx_q <= DIM_W'(rem_v[1]);
                        got   <= '0;
                        go    <= 1'b1;
                        ph    <= PH_SPLIT2;
                    end else begin
                        got <= got | fin_bits;
                    end
                end
                PH_SPLIT2: begin
                    if (both_fin) begin
                        wgy_q <= DIM_W'(rem_v[1]);
                        wgz_q <= GRP_W'(quo_v[1]);
                        got   <= '0;
                        ph    <= PH_WALK;
                    end else begin
                        got <= got | fin_bits;
                    end
                end
                PH_WALK: begin
                    lane_vld  <= 1'b1;
                    lane_idx  <= walk_lane;
                    lane_x    <= walk_x;
                    lane_y    <= walk_y;
                    lane_z    <= walk_z;
                    lane_flat <= walk_flat;
                    lane_on   <= walk_on;
                    mask_acc[walk_lane] <= walk_on;
                    if (walk_last) begin
                        ph <= PH_FIN;
                    end
                end
                PH_FIN: begin
                    done      <= 1'b1;
                    exec_mask <= mask_acc;
                    grp_x     <= wgx_q;
                    grp_y     <= wgy_q;
                    grp_z     <= wgz_q;
                    ph        <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // walk_g feeds the live test inside the walker; keep it visible here too
    logic unused_g;
    assign unused_g = ^walk_g;
endmodule

// File: rtl/wid_lane_gen_chk.sv
module wid_lane_gen_chk
    import wid_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned DIM_W  = DEF_DIM_W,
    parameter int unsigned WAVE_W = DEF_WAVE_W
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                start,
    input logic [DIM_W-1:0]                    size_x,
    input logic [DIM_W-1:0]                    size_y,
    input logic [WAVE_W+lane_bits(LANES):0]    item_total,
    input logic [WAVE_W-1:0]                   wave_idx,
    input logic                                busy,
    input logic                                lane_vld,
    input logic [lane_bits(LANES)-1:0]         lane_idx,
    input logic [DIM_W-1:0]                    lane_x,
    input logic [DIM_W-1:0]                    lane_y,
    input logic [WAVE_W+lane_bits(LANES)-1:0]  lane_flat,
    input logic                                lane_on,
    input logic                                done,
    input logic [LANES-1:0]                    exec_mask
);
    localparam int unsigned LB    = lane_bits(LANES);
    localparam int unsigned G_W   = WAVE_W + LB;
    localparam int unsigned TOT_W = G_W + 1;
    localparam int unsigned EW    = DIM_W + 1;

    logic [DIM_W-1:0] c_sx, c_sy;
    logic [TOT_W-1:0] c_tot;
    logic [G_W-1:0]   c_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_sx   <= DIM_W'(1);
            c_sy   <= DIM_W'(1);
            c_tot  <= '0;
            c_base <= '0;
        end else if (start && !busy) begin
            c_sx   <= (size_x == '0) ? DIM_W'(1) : size_x;
            c_sy   <= (size_y == '0) ? DIM_W'(1) : size_y;
            c_tot  <= item_total;
            c_base <= G_W'(wave_idx) * G_W'(LANES);
        end
    end

    p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    p_first_lane_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_vld) |-> lane_idx == '0);

    p_lane_seq_r2: assert property (@(posedge clk) disable iff (rst)
        lane_vld && $past(lane_vld) |-> lane_idx == LB'($past(lane_idx) + LB'(1)));

    p_flat_item_r3: assert property (@(posedge clk) disable iff (rst)
        lane_vld |-> lane_flat == c_base + G_W'(lane_idx));

    p_coord_range_r4: assert property (@(posedge clk) disable iff (rst)
        lane_vld |-> (lane_x < c_sx) && (lane_y < c_sy));

    p_x_step_r4: assert property (@(posedge clk) disable iff (rst)
        lane_vld && $past(lane_vld) && (EW'($past(lane_x)) + EW'(1) < EW'(c_sx))
        |-> (lane_x == DIM_W'($past(lane_x) + DIM_W'(1))) && (lane_y == $past(lane_y)));

    p_live_r5: assert property (@(posedge clk) disable iff (rst)
        lane_vld |-> lane_on == ((TOT_W'(c_base) + TOT_W'(lane_idx)) < c_tot));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        lane_vld && (lane_idx == LB'(LANES - 1)) |=> done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !lane_vld);

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(exec_mask));
endmodule

bind wid_lane_gen wid_lane_gen_chk #(
    .LANES  (LANES),
    .DIM_W  (DIM_W),
    .WAVE_W (WAVE_W)
) chk_i (.*);

// File: tb/wid_lane_gen_tb_top.sv
module wid_lane_gen_tb_top;
    localparam int LANES  = 16;
    localparam int DIM_W  = 8;
    localparam int WAVE_W = 8;
    localparam int GRP_W  = 16;
    localparam int LB     = 4;
    localparam int G_W    = WAVE_W + LB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DIM_W-1:0]  size_x = '0, size_y = '0, grp_cnt_x = '0, grp_cnt_y = '0;
    logic [G_W:0]      item_total = '0;
    logic [WAVE_W-1:0] wave_idx = '0;
    logic [GRP_W-1:0]  grp_id = '0;

    logic              busy, lane_vld, lane_on, done;
    logic [LB-1:0]     lane_idx;
    logic [DIM_W-1:0]  lane_x, lane_y, grp_x, grp_y;
    logic [G_W-1:0]    lane_z, lane_flat;
    logic [LANES-1:0]  exec_mask;
    logic [GRP_W-1:0]  grp_z;

    always #5 clk = ~clk;

    wid_lane_gen #(.LANES(LANES), .DIM_W(DIM_W), .WAVE_W(WAVE_W), .GRP_W(GRP_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .size_x(size_x), .size_y(size_y),
        .item_total(item_total), .wave_idx(wave_idx), .grp_id(grp_id),
        .grp_cnt_x(grp_cnt_x), .grp_cnt_y(grp_cnt_y), .busy(busy),
        .lane_vld(lane_vld), .lane_idx(lane_idx), .lane_x(lane_x), .lane_y(lane_y),
        .lane_z(lane_z), .lane_flat(lane_flat), .lane_on(lane_on), .done(done),
        .exec_mask(exec_mask), .grp_x(grp_x), .grp_y(grp_y), .grp_z(grp_z)
    );

    typedef struct { int idx; int x; int y; int z; int flat; int on; } lane_exp_t;
    typedef struct { int mask; int gx; int gy; int gz; } fin_exp_t;

    lane_exp_t lane_q[$];
    fin_exp_t  fin_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int last_mask = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (lane_vld) begin
                if (lane_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected lane record", int'(lane_idx), -1);
                end else begin
                    lane_exp_t e;
                    string ct;
                    e = lane_q.pop_front();
                    ct = (e.on != 0) ? "R4" : "R6";
                    chk(int'(lane_idx) == e.idx, "R2 lane_idx", int'(lane_idx), e.idx);
                    chk(int'(lane_x) == e.x, {ct, " lane_x"}, int'(lane_x), e.x);
                    chk(int'(lane_y) == e.y, {ct, " lane_y"}, int'(lane_y), e.y);
                    chk(int'(lane_z) == e.z, {ct, " lane_z"}, int'(lane_z), e.z);
                    chk(int'(lane_flat) == e.flat, "R3 lane_flat", int'(lane_flat), e.flat);
                    chk(int'(lane_on) == e.on, "R5 lane_on", int'(lane_on), e.on);
                end
            end
            if (done) begin
                if (fin_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    fin_exp_t f;
                    f = fin_q.pop_front();
                    chk(lane_q.size() == 0, "R7 done before all lanes", lane_q.size(), 0);
                    chk(int'(exec_mask) == f.mask, "R7 exec_mask", int'(exec_mask), f.mask);
                    chk(int'(grp_x) == f.gx, "R8 grp_x", int'(grp_x), f.gx);
                    chk(int'(grp_y) == f.gy, "R8 grp_y", int'(grp_y), f.gy);
                    chk(int'(grp_z) == f.gz, "R8 grp_z", int'(grp_z), f.gz);
                    last_mask = f.mask;
                end
                done_cnt++;
            end
        end
    end

    // Driver: compute expectations from the requirements, then launch
    task automatic run_case(input int sx, input int sy, input int tot, input int wave,
                            input int gid, input int nx, input int ny, input bit poke);
        int esx, esy, enx, eny, target;
        fin_exp_t f;
        esx = (sx == 0) ? 1 : sx;   // R9 clamping
        esy = (sy == 0) ? 1 : sy;
        enx = (nx == 0) ? 1 : nx;
        eny = (ny == 0) ? 1 : ny;
        f.mask = 0;
        for (int k = 0; k < LANES; k++) begin
            lane_exp_t e;
            int g;
            g = k + wave * LANES;
            e.idx = k;
            e.x = g % esx;
            e.y = (g / esx) % esy;
            e.z = g / (esx * esy);
            e.flat = g;
            e.on = (g < tot) ? 1 : 0;
            if (g < tot) f.mask = f.mask | (1 << k);
            lane_q.push_back(e);
        end
        f.gx = gid % enx;
        f.gy = (gid / enx) % eny;
        f.gz = gid / (enx * eny);
        fin_q.push_back(f);
        target = done_cnt + 1;

        @(negedge clk);
        size_x = DIM_W'(sx); size_y = DIM_W'(sy); item_total = (G_W+1)'(tot);
        wave_idx = WAVE_W'(wave); grp_id = GRP_W'(gid);
        grp_cnt_x = DIM_W'(nx); grp_cnt_y = DIM_W'(ny);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        if (poke) begin
            // R1: a request while busy must leave this run untouched
            repeat (3) @(negedge clk);
            wave_idx = WAVE_W'(wave + 5); size_x = DIM_W'(esx + 1); item_total = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(lane_q.size() == 0, "R2 records per run", LANES - lane_q.size(), LANES);
        chk(busy == 1'b0, "R1 idle after run", int'(busy), 0);
        chk(int'(exec_mask) == last_mask, "R7 mask held", int'(exec_mask), last_mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy", int'(busy), 0);
        chk(lane_vld == 1'b0, "R10 lane_vld", int'(lane_vld), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
        chk(exec_mask == '0, "R10 exec_mask", int'(exec_mask), 0);
        chk(grp_z == '0, "R10 grp_z", int'(grp_z), 0);

        run_case(4, 3, 40, 0, 7, 3, 2, 1'b0);        // full wave, Y and Z carries
        run_case(4, 3, 40, 2, 29, 4, 5, 1'b0);       // partial wave R5 R6
        run_case(5, 2, 200, 3, 1000, 10, 7, 1'b1);   // start while busy R1
        run_case(0, 0, 20, 1, 5, 0, 0, 1'b0);        // zero extents R9
        run_case(1, 16, 16, 0, 65535, 255, 255, 1'b0);
        run_case(7, 3, 0, 4, 0, 1, 1, 1'b0);         // nothing live R5 R7
        run_case(200, 3, 4095, 100, 321, 16, 4, 1'b0);
        run_case(16, 1, 3, 0, 12, 3, 3, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule